// File: doc/BRIEF.md
# In-Order Retirement Buffer with Register Tag Indirection

This block keeps precise architectural state in a pipeline whose functional units finish out of program order. Each decoded instruction claims the next slot of a circular buffer and gets a slot tag back. When a unit finishes, it reports the tag, the result (or store data), the store address and a fault flag. That report fills the slot only. Retirement always takes the oldest slot. A clean, finished register instruction writes the architectural register file. A clean, finished store is handed to memory through a one-cycle store strobe.

Each architectural register also records whether a write to it is still in flight, and which slot will produce that write. An operand lookup reads that record first. If the register has no pending writer, the lookup returns the architectural value. If it has one, the lookup uses the recorded tag to read that single slot, so no associative search of the buffer is needed.

When the oldest slot finished with a fault, the block raises a one-cycle redirect to a fixed handler address and reports the faulting instruction's PC. In the same edge it frees every slot, clears every pending-writer record and restarts the tags at zero.

Top module: `rob_commit_unit`

## Requirements
- R1: After reset the buffer is empty. `alloc_ready` is 1, `commit_valid` and `redirect_valid` are 0, and every register lookup returns `rd_ready`=1 with value 0.
- R2: An allocation is accepted on an edge where `alloc_valid` and `alloc_ready` are both 1. The tag it receives is the value `alloc_tag` showed before that edge. Tags are handed out as consecutive integers modulo DEPTH.
- R3: With DEPTH slots occupied, `alloc_ready` is 0. An `alloc_valid` in that state consumes no tag and maps no register.
- R4: A completion marks only its own slot as done. A lookup of a register whose pending writer has finished returns `rd_ready`=1 with that writer's value. A lookup of a register whose writer has not finished returns `rd_ready`=0.
- R5: `commit_valid` is 1 only while the oldest slot is done without a fault. Finished younger slots wait until every older slot has retired. Each retirement frees one slot at the next edge.
- R6: Retiring a register instruction shows its destination and value on `commit_dst` and `commit_value`, and writes that value into the architectural register at the edge.
- R7: On retirement, a register's pending-writer record is cleared only if it still names the retiring slot. If a younger writer to the same register is in flight, lookups keep reporting that writer's tag with `rd_ready`=0.
- R8: Retiring a store raises `st_valid` together with `commit_valid`, with `st_addr` and `st_data` taken from its completion. A store neither maps nor writes its destination register field.
- R9: When the oldest slot is done with a fault, `redirect_valid` is 1 for exactly one cycle, `redirect_pc` equals HANDLER_PC, `exc_pc` equals that slot's PC, and `commit_valid` is 0. After that edge, all slots are free, every lookup returns the architectural value with `rd_ready`=1, and the next tag is 0.
- R10: A fault reported on a slot that is not the oldest raises nothing until every older slot has retired.
- R11: While a register has a pending writer, `rd_tag` gives the tag of the youngest accepted writer to that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Decode requests a slot |
| alloc_is_store | input | 1 | Requesting instruction is a store |
| alloc_dst | input | $clog2(NREG) | Destination register of the requesting instruction |
| alloc_pc | input | XLEN | PC of the requesting instruction |
| alloc_ready | output | 1 | A slot can be taken this cycle |
| alloc_tag | output | $clog2(DEPTH) | Tag the next accepted allocation receives |
| cmpl_valid | input | 1 | A functional unit reports a finished instruction |
| cmpl_tag | input | $clog2(DEPTH) | Slot of the finished instruction |
| cmpl_value | input | XLEN | Result, or store data for a store |
| cmpl_addr | input | XLEN | Store address (ignored for register instructions) |
| cmpl_exc | input | 1 | Instruction faulted |
| rd_reg | input | $clog2(NREG) | Register for operand lookup |
| rd_ready | output | 1 | Lookup value is available |
| rd_tag | output | $clog2(DEPTH) | Slot of the pending writer |
| rd_value | output | XLEN | Operand value |
| commit_valid | output | 1 | Oldest slot retires at this edge |
| commit_dst | output | $clog2(NREG) | Destination of the retiring instruction |
| commit_value | output | XLEN | Value of the retiring instruction |
| st_valid | output | 1 | Retiring instruction is a store |
| st_addr | output | XLEN | Store address |
| st_data | output | XLEN | Store data |
| redirect_valid | output | 1 | Fault at the oldest slot: flush and redirect |
| redirect_pc | output | XLEN | Handler address |
| exc_pc | output | XLEN | PC of the faulting instruction |

## Verification
The bench builds the block with DEPTH=4 and NREG=8. With only four slots, six in-order allocations already wrap the tag counter, and the full condition and a rejected allocation can be reached in a handful of cycles. In the same short sequence, a younger fault can be made to wait behind two older slots and then flush a buffer that still holds entries. Eight registers leave room to give every test its own destinations, so that arch values written by earlier tests stay predictable for the lookups after the flush.

// File: rtl/rob_pkg.sv
// Package: shared types for the retirement buffer.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package rob_pkg;
    // Life cycle of one buffer slot.
    typedef enum logic [1:0] {
        SLOT_FREE = 2'd0,
        SLOT_BUSY = 2'd1,
        SLOT_DONE = 2'd2
    } slot_state_e;

    // Action taken on the oldest slot in a cycle.
    typedef enum logic [1:0] {
        RET_IDLE   = 2'd0,
        RET_COMMIT = 2'd1,
        RET_TRAP   = 2'd2
    } retire_act_e;
endpackage

// File: rtl/rob_ring_ctrl.sv
// Module: head/tail pointers and occupancy of the circular slot buffer.
// Assumes: alloc_fire is never raised when full; retire_fire never when empty;
// flush outranks both and returns the ring to slot 0.
module rob_ring_ctrl #(
    parameter int DEPTH = 16,
    localparam int TW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_fire,
    input  logic          retire_fire,
    input  logic          flush,
    output logic [TW-1:0] head,
    output logic [TW-1:0] tail,
    output logic [CW-1:0] occ,
    output logic          full
);
    localparam logic [TW-1:0] LAST = TW'(DEPTH - 1);

    logic [TW-1:0] head_q, tail_q;
    logic [CW-1:0] occ_q;

    // Advance pointers with wrap and track how many slots are taken.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            head_q <= '0;
            tail_q <= '0;
            occ_q  <= '0;
        end else begin
            if (alloc_fire)
                tail_q <= (tail_q == LAST) ? '0 : tail_q + 1'b1;
            if (retire_fire)
                head_q <= (head_q == LAST) ? '0 : head_q + 1'b1;
            occ_q <= occ_q + CW'(alloc_fire) - CW'(retire_fire);
        end
    end

    assign head = head_q;
    assign tail = tail_q;
    assign occ  = occ_q;
    assign full = (occ_q == CW'(DEPTH));
endmodule

// File: rtl/rob_entry_array.sv
// Module: per-slot storage (state, destination, kind, PC, value, store
// address, fault flag) with one write port each for allocation, completion
// and retirement, a read port at the head and a read port for lookups.
// Assumes: allocation and retirement never target the same slot in a cycle;
// a completion to a slot that is not busy is dropped.
module rob_entry_array
    import rob_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int NREG  = 32,
    parameter int XLEN  = 32,
    localparam int TW = $clog2(DEPTH),
    localparam int RW = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          alloc_we,
    input  logic [TW-1:0] alloc_idx,
    input  logic [RW-1:0] alloc_dst,
    input  logic          alloc_is_store,
    input  logic [XLEN-1:0] alloc_pc,
    input  logic          cmpl_we,
    input  logic [TW-1:0] cmpl_idx,
    input  logic [XLEN-1:0] cmpl_value,
    input  logic [XLEN-1:0] cmpl_addr,
    input  logic          cmpl_exc,
    input  logic          retire_we,
    input  logic [TW-1:0] head_idx,
    output slot_state_e   head_state,
    output logic [RW-1:0] head_dst,
    output logic          head_is_store,
    output logic [XLEN-1:0] head_pc,
    output logic [XLEN-1:0] head_value,
    output logic [XLEN-1:0] head_addr,
    output logic          head_exc,
    input  logic [TW-1:0] look_idx,
    output slot_state_e   look_state,
    output logic [XLEN-1:0] look_value
);
    slot_state_e     st_q   [DEPTH];
    logic [RW-1:0]   dst_q  [DEPTH];
    logic            sto_q  [DEPTH];
    logic [XLEN-1:0] pc_q   [DEPTH];
    logic [XLEN-1:0] val_q  [DEPTH];
    logic [XLEN-1:0] addr_q [DEPTH];
    logic            exc_q  [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        // One slot: claim at decode, fill at completion, free at retire/flush.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q[i]   <= SLOT_FREE;
                dst_q[i]  <= '0;
                sto_q[i]  <= 1'b0;
                pc_q[i]   <= '0;
                val_q[i]  <= '0;
                addr_q[i] <= '0;
                exc_q[i]  <= 1'b0;
            end else if (flush) begin
                st_q[i] <= SLOT_FREE;
            end else if (alloc_we && alloc_idx == TW'(i)) begin
                st_q[i]  <= SLOT_BUSY;
                dst_q[i] <= alloc_dst;
                sto_q[i] <= alloc_is_store;
                pc_q[i]  <= alloc_pc;
                exc_q[i] <= 1'b0;
            end else if (cmpl_we && cmpl_idx == TW'(i) && st_q[i] == SLOT_BUSY) begin
                st_q[i]   <= SLOT_DONE;
                val_q[i]  <= cmpl_value;
                addr_q[i] <= cmpl_addr;
                exc_q[i]  <= cmpl_exc;
            end else if (retire_we && head_idx == TW'(i)) begin
                st_q[i] <= SLOT_FREE;
            end
        end
    end

    // Head read port feeds retirement.
    assign head_state    = st_q[head_idx];
    assign head_dst      = dst_q[head_idx];
    assign head_is_store = sto_q[head_idx];
    assign head_pc       = pc_q[head_idx];
    assign head_value    = val_q[head_idx];
    assign head_addr     = addr_q[head_idx];
    assign head_exc      = exc_q[head_idx];

    // Indirect read port feeds operand lookup.
    assign look_state = st_q[look_idx];
    assign look_value = val_q[look_idx];
endmodule

// File: rtl/rob_rename_map.sv
// Module: architectural register values plus, per register, a pending flag
// and the tag of its youngest in-flight writer.
// Assumes: commit and flush never occur in the same cycle; an allocation to a
// register outranks the release of that register's record by a retirement.
module rob_rename_map #(
    parameter int DEPTH = 16,
    parameter int NREG  = 32,
    parameter int XLEN  = 32,
    localparam int TW = $clog2(DEPTH),
    localparam int RW = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          map_we,
    input  logic [RW-1:0] map_reg,
    input  logic [TW-1:0] map_tag,
    input  logic          rf_we,
    input  logic [RW-1:0] rf_reg,
    input  logic [TW-1:0] rf_tag,
    input  logic [XLEN-1:0] rf_value,
    input  logic [RW-1:0] q_reg,
    output logic          q_pending,
    output logic [TW-1:0] q_tag,
    output logic [XLEN-1:0] q_value
);
    logic            pend_q [NREG];
    logic [TW-1:0]   tag_q  [NREG];
    logic [XLEN-1:0] arch_q [NREG];

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        // Architectural value: written only by a retiring register instruction.
        always_ff @(posedge clk) begin
            if (!rst_n)
                arch_q[r] <= '0;
            else if (rf_we && rf_reg == RW'(r))
                arch_q[r] <= rf_value;
        end

        // Pending-writer record: set at decode, released by its own retirement.
        always_ff @(posedge clk) begin
            if (!rst_n || flush) begin
                pend_q[r] <= 1'b0;
                tag_q[r]  <= '0;
            end else if (map_we && map_reg == RW'(r)) begin
                pend_q[r] <= 1'b1;
                tag_q[r]  <= map_tag;
            end else if (rf_we && rf_reg == RW'(r) && tag_q[r] == rf_tag) begin
                pend_q[r] <= 1'b0;
            end
        end
    end

    assign q_pending = pend_q[q_reg];
    assign q_tag     = tag_q[q_reg];
    assign q_value   = arch_q[q_reg];
endmodule

// File: rtl/rob_retire_ctrl.sv
// Module: decides what the oldest slot does this cycle.
// Assumes: head_state is SLOT_FREE whenever the buffer is empty.
module rob_retire_ctrl
    import rob_pkg::*;
(
    input  slot_state_e head_state,
    input  logic        head_exc,
    input  logic        head_is_store,
    output logic        retire_fire,
    output logic        trap,
    output logic        rf_we,
    output logic        st_fire
);
    retire_act_e act;

    // Pick commit, trap or wait from the head slot's status.
    always_comb begin
        act = RET_IDLE;
        if (head_state == SLOT_DONE)
            act = head_exc ? RET_TRAP : RET_COMMIT;
    end

    assign retire_fire = (act == RET_COMMIT);
    assign trap        = (act == RET_TRAP);
    assign rf_we       = retire_fire && !head_is_store;
    assign st_fire     = retire_fire && head_is_store;
endmodule

// File: rtl/rob_commit_unit.sv
// Module: top of the retirement buffer. Joins the ring pointers, slot
// storage, register map and retire decision; resolves operand lookups.
// Assumes: cmpl_tag names a slot allocated earlier; HANDLER_PC is fixed.
module rob_commit_unit
    import rob_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int NREG  = 32,
    parameter int XLEN  = 32,
    parameter logic [XLEN-1:0] HANDLER_PC = XLEN'(32'h0000_1000),
    localparam int TW = $clog2(DEPTH),
    localparam int RW = $clog2(NREG),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            alloc_valid,
    input  logic            alloc_is_store,
    input  logic [RW-1:0]   alloc_dst,
    input  logic [XLEN-1:0] alloc_pc,
    output logic            alloc_ready,
    output logic [TW-1:0]   alloc_tag,
    input  logic            cmpl_valid,
    input  logic [TW-1:0]   cmpl_tag,
    input  logic [XLEN-1:0] cmpl_value,
    input  logic [XLEN-1:0] cmpl_addr,
    input  logic            cmpl_exc,
    input  logic [RW-1:0]   rd_reg,
    output logic            rd_ready,
    output logic [TW-1:0]   rd_tag,
    output logic [XLEN-1:0] rd_value,
    output logic            commit_valid,
    output logic [RW-1:0]   commit_dst,
    output logic [XLEN-1:0] commit_value,
    output logic            st_valid,
    output logic [XLEN-1:0] st_addr,
    output logic [XLEN-1:0] st_data,
    output logic            redirect_valid,
    output logic [XLEN-1:0] redirect_pc,
    output logic [XLEN-1:0] exc_pc
);
    logic [TW-1:0]   head, tail;
    logic [CW-1:0]   occ;
    logic            full, alloc_fire, retire_fire, trap, rf_we, st_fire;
    slot_state_e     head_state, look_state;
    logic [RW-1:0]   head_dst;
    logic            head_is_store, head_exc;
    logic [XLEN-1:0] head_pc, head_value, head_addr, look_value, arch_value;
    logic            map_pending;
    logic [TW-1:0]   map_tag;

    assign alloc_ready = !full && !trap;
    assign alloc_fire  = alloc_valid && alloc_ready;
    assign alloc_tag   = tail;

    rob_ring_ctrl #(.DEPTH(DEPTH)) u_ring (
        .clk(clk), .rst_n(rst_n),
        .alloc_fire(alloc_fire), .retire_fire(retire_fire), .flush(trap),
        .head(head), .tail(tail), .occ(occ), .full(full)
    );

    rob_entry_array #(.DEPTH(DEPTH), .NREG(NREG), .XLEN(XLEN)) u_slots (
        .clk(clk), .rst_n(rst_n), .flush(trap),
        .alloc_we(alloc_fire), .alloc_idx(tail), .alloc_dst(alloc_dst),
        .alloc_is_store(alloc_is_store), .alloc_pc(alloc_pc),
        .cmpl_we(cmpl_valid), .cmpl_idx(cmpl_tag), .cmpl_value(cmpl_value),
        .cmpl_addr(cmpl_addr), .cmpl_exc(cmpl_exc),
        .retire_we(retire_fire), .head_idx(head),
        .head_state(head_state), .head_dst(head_dst),
        .head_is_store(head_is_store), .head_pc(head_pc),
        .head_value(head_value), .head_addr(head_addr), .head_exc(head_exc),
        .look_idx(map_tag), .look_state(look_state), .look_value(look_value)
    );

    rob_rename_map #(.DEPTH(DEPTH), .NREG(NREG), .XLEN(XLEN)) u_map (
        .clk(clk), .rst_n(rst_n), .flush(trap),
        .map_we(alloc_fire && !alloc_is_store), .map_reg(alloc_dst), .map_tag(tail),
        .rf_we(rf_we), .rf_reg(head_dst), .rf_tag(head), .rf_value(head_value),
        .q_reg(rd_reg), .q_pending(map_pending), .q_tag(map_tag), .q_value(arch_value)
    );

    rob_retire_ctrl u_retire (
        .head_state(head_state), .head_exc(head_exc), .head_is_store(head_is_store),
        .retire_fire(retire_fire), .trap(trap), .rf_we(rf_we), .st_fire(st_fire)
    );

    // Operand lookup: register file first, then the slot it points to.
    always_comb begin
        rd_tag = map_tag;
        if (map_pending) begin
            rd_ready = (look_state == SLOT_DONE);
            rd_value = look_value;
        end else begin
            rd_ready = 1'b1;
            rd_value = arch_value;
        end
    end

    assign commit_valid   = retire_fire;
    assign commit_dst     = head_dst;
    assign commit_value   = head_value;
    assign st_valid       = st_fire;
    assign st_addr        = head_addr;
    assign st_data        = head_value;
    assign redirect_valid = trap;
    assign redirect_pc    = HANDLER_PC;
    assign exc_pc         = head_pc;
endmodule

// File: rtl/rob_commit_checker.sv
// Module: temporal checks on the retirement buffer, bound to the top.
// Assumes: occ is the top's occupancy count.
module rob_commit_checker #(
    parameter int DEPTH = 16,
    parameter int CW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          alloc_valid,
    input logic          alloc_ready,
    input logic          commit_valid,
    input logic          st_valid,
    input logic          redirect_valid,
    input logic [CW-1:0] occ
);
    a_r3_occ_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CW'(DEPTH));

    a_r3_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        occ == CW'(DEPTH) |-> !alloc_ready);

    a_r2_alloc_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && alloc_ready && !commit_valid) |=> occ == $past(occ) + 1'b1);

    a_r5_retire_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_valid && !(alloc_valid && alloc_ready)) |=> occ == $past(occ) - 1'b1);

    a_r8_store_is_commit: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> commit_valid);

    a_r9_no_commit_on_trap: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit_valid && redirect_valid));

    a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> occ == '0);

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> !redirect_valid);
endmodule

bind rob_commit_unit rob_commit_checker #(.DEPTH(DEPTH), .CW(CW)) u_rob_chk (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .commit_valid(commit_valid), .st_valid(st_valid),
    .redirect_valid(redirect_valid), .occ(occ)
);

// File: tb/rob_commit_unit_bench.sv
// Bench: drives inputs and samples outputs at the falling edge.
module rob_commit_unit_bench;
    localparam int DEPTH = 4;
    localparam int NREG  = 8;
    localparam int XLEN  = 32;
    localparam logic [31:0] HPC = 32'h0000_0800;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_valid = 0, alloc_is_store = 0;
    logic [2:0]  alloc_dst = '0;
    logic [31:0] alloc_pc = '0;
    logic        alloc_ready;
    logic [1:0]  alloc_tag;
    logic        cmpl_valid = 0, cmpl_exc = 0;
    logic [1:0]  cmpl_tag = '0;
    logic [31:0] cmpl_value = '0, cmpl_addr = '0;
    logic [2:0]  rd_reg = '0;
    logic        rd_ready;
    logic [1:0]  rd_tag;
    logic [31:0] rd_value;
    logic        commit_valid, st_valid, redirect_valid;
    logic [2:0]  commit_dst;
    logic [31:0] commit_value, st_addr, st_data, redirect_pc, exc_pc;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;
    logic [1:0]  exp_tag = '0;
    logic [31:0] arch [NREG];

    always #2.5 clk = ~clk;

    rob_commit_unit #(.DEPTH(DEPTH), .NREG(NREG), .XLEN(XLEN), .HANDLER_PC(HPC)) u_rob_commit_unit (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_is_store(alloc_is_store),
        .alloc_dst(alloc_dst), .alloc_pc(alloc_pc),
        .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
        .cmpl_valid(cmpl_valid), .cmpl_tag(cmpl_tag), .cmpl_value(cmpl_value),
        .cmpl_addr(cmpl_addr), .cmpl_exc(cmpl_exc),
        .rd_reg(rd_reg), .rd_ready(rd_ready), .rd_tag(rd_tag), .rd_value(rd_value),
        .commit_valid(commit_valid), .commit_dst(commit_dst), .commit_value(commit_value),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .exc_pc(exc_pc)
    );

    // Rows: {destination register[34:32], result value[31:0]}.
    localparam logic [34:0] VEC [6] = '{
        {3'd1, 32'h0000_0011}, {3'd2, 32'h0000_0022}, {3'd3, 32'h1234_5678},
        {3'd4, 32'hFFFF_FFFF}, {3'd1, 32'h0000_0F0F}, {3'd7, 32'h8000_0001}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_alloc(input logic [2:0] dst, input bit st, input logic [31:0] pc,
                            output logic [1:0] tg);
        chk("R2 alloc_tag", 64'(alloc_tag), 64'(exp_tag));
        tg = exp_tag;
        alloc_valid = 1; alloc_dst = dst; alloc_is_store = st; alloc_pc = pc;
        step();
        alloc_valid = 0; alloc_is_store = 0;
        exp_tag = exp_tag + 1'b1;
    endtask

    task automatic do_cmpl(input logic [1:0] tg, input logic [31:0] v,
                           input logic [31:0] a, input bit e);
        cmpl_valid = 1; cmpl_tag = tg; cmpl_value = v; cmpl_addr = a; cmpl_exc = e;
        step();
        cmpl_valid = 0; cmpl_exc = 0;
    endtask

    task automatic look(input logic [2:0] r, input bit exp_rdy, input logic [31:0] exp_v,
                        input string req);
        rd_reg = r;
        #0.5;
        chk({req, " rd_ready"}, 64'(rd_ready), 64'(exp_rdy));
        if (exp_rdy) chk({req, " rd_value"}, 64'(rd_value), 64'(exp_v));
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [1:0] t, ta, tb, tc, td, ts, e1, e2, e3, e4;
        for (int i = 0; i < NREG; i++) arch[i] = '0;
        repeat (3) step();
        rst_n = 1;
        step();

        // R1: reset state
        chk("R1 alloc_ready", 64'(alloc_ready), 1);
        chk("R1 commit_valid", 64'(commit_valid), 0);
        chk("R1 redirect_valid", 64'(redirect_valid), 0);
        look(3'd3, 1, 32'h0, "R1");

        // R2/R5/R6: table walk, tags wrap after four rows
        for (int k = 0; k < 6; k++) begin
            logic [2:0]  d;
            logic [31:0] v;
            d = VEC[k][34:32];
            v = VEC[k][31:0];
            do_alloc(d, 0, 32'h40 + 32'(k) * 4, t);
            chk("R5 no commit before completion", 64'(commit_valid), 0);
            do_cmpl(t, v, 32'h0, 0);
            chk("R5 commit_valid", 64'(commit_valid), 1);
            chk("R6 commit_dst", 64'(commit_dst), 64'(d));
            chk("R6 commit_value", 64'(commit_value), 64'(v));
            chk("R8 st_valid on register op", 64'(st_valid), 0);
            arch[d] = v;
            step();
            look(d, 1, v, "R6");
        end

        // R4/R5/R11: younger finishes first
        do_alloc(3'd5, 0, 32'h100, ta);
        do_alloc(3'd6, 0, 32'h104, tb);
        do_cmpl(tb, 32'h0000_0B0B, 32'h0, 0);
        chk("R5 younger waits", 64'(commit_valid), 0);
        look(3'd6, 1, 32'h0000_0B0B, "R4");
        chk("R11 rd_tag", 64'(rd_tag), 64'(tb));
        look(3'd5, 0, 32'h0, "R4");
        chk("R11 rd_tag pending", 64'(rd_tag), 64'(ta));
        do_cmpl(ta, 32'h0000_0A0A, 32'h0, 0);
        chk("R5 oldest commits", 64'(commit_valid), 1);
        chk("R5 oldest dst", 64'(commit_dst), 5);
        step();
        chk("R5 next commits", 64'(commit_valid), 1);
        chk("R5 next dst", 64'(commit_dst), 6);
        chk("R5 next value", 64'(commit_value), 64'h0B0B);
        step();
        chk("R5 empty no commit", 64'(commit_valid), 0);
        arch[5] = 32'h0A0A; arch[6] = 32'h0B0B;

        // R7: two writers to the same register
        do_alloc(3'd2, 0, 32'h200, tc);
        do_alloc(3'd2, 0, 32'h204, td);
        do_cmpl(tc, 32'h0000_0C0C, 32'h0, 0);
        chk("R7 older commits", 64'(commit_value), 64'h0C0C);
        step();
        look(3'd2, 0, 32'h0, "R7");
        chk("R7 rd_tag younger", 64'(rd_tag), 64'(td));
        do_cmpl(td, 32'h0000_0D0D, 32'h0, 0);
        step();
        look(3'd2, 1, 32'h0000_0D0D, "R7");
        arch[2] = 32'h0D0D;

        // R8: store retires to memory, register field untouched
        do_alloc(3'd6, 1, 32'h300, ts);
        look(3'd6, 1, arch[6], "R8 store maps nothing");
        do_cmpl(ts, 32'h0000_5AFE, 32'h0000_0100, 0);
        chk("R8 commit_valid", 64'(commit_valid), 1);
        chk("R8 st_valid", 64'(st_valid), 1);
        chk("R8 st_addr", 64'(st_addr), 64'h100);
        chk("R8 st_data", 64'(st_data), 64'h5AFE);
        step();
        look(3'd6, 1, arch[6], "R8 no register write");

        // R3: fill the buffer, try a fifth
        do_alloc(3'd1, 0, 32'h400, e1);
        do_alloc(3'd3, 0, 32'h404, e2);
        do_alloc(3'd4, 0, 32'h408, e3);
        do_alloc(3'd7, 0, 32'h40C, e4);
        chk("R3 alloc_ready full", 64'(alloc_ready), 0);
        alloc_valid = 1; alloc_dst = 3'd0; alloc_pc = 32'h410;
        step();
        alloc_valid = 0;
        look(3'd0, 1, arch[0], "R3 rejected maps nothing");

        // R10: younger fault waits behind older slots
        do_cmpl(e3, 32'hDEAD_0000, 32'h0, 1);
        chk("R10 no redirect yet", 64'(redirect_valid), 0);
        do_cmpl(e1, 32'h0000_1111, 32'h0, 0);
        chk("R10 older commits", 64'(commit_valid), 1);
        arch[1] = 32'h1111;
        step();
        chk("R10 waits for e2", 64'(redirect_valid), 0);
        chk("R3 ready after retire", 64'(alloc_ready), 1);
        chk("R3 rejected took no tag", 64'(alloc_tag), 64'(exp_tag));
        do_cmpl(e2, 32'h0000_3333, 32'h0, 0);
        chk("R10 e2 commits", 64'(commit_valid), 1);
        arch[3] = 32'h3333;
        step();

        // R9: fault at head
        chk("R9 redirect_valid", 64'(redirect_valid), 1);
        chk("R9 redirect_pc", 64'(redirect_pc), 64'(HPC));
        chk("R9 exc_pc", 64'(exc_pc), 64'h408);
        chk("R9 no commit", 64'(commit_valid), 0);
        step();
        exp_tag = '0;
        chk("R9 single pulse", 64'(redirect_valid), 0);
        chk("R9 alloc_ready", 64'(alloc_ready), 1);
        chk("R9 tag restart", 64'(alloc_tag), 0);
        look(3'd4, 1, arch[4], "R9");
        look(3'd7, 1, arch[7], "R9");
        look(3'd3, 1, 32'h3333, "R9");

        // R2: buffer works again after the flush
        do_alloc(3'd0, 0, 32'h500, t);
        do_cmpl(t, 32'h0000_0E0E, 32'h0, 0);
        chk("R2 commit after flush", 64'(commit_value), 64'h0E0E);
        step();
        look(3'd0, 1, 32'h0000_0E0E, "R6");

        summary();
    end
endmodule